// File: doc/BRIEF.md
# Dual Linear Congruential Pattern Generator

This block supplies stimulus for a field-extraction test. It holds two independent 16-bit linear congruential generators. Each computes its successor as `(2053 * x + c) mod 2^16`. The multiply is done with shifted adds only: `x + (x << 2) + (x << 11)`. A single advance strobe steps both generators in the same clock cycle.

The upper byte of generator A's state is presented as a field descriptor. Its high nibble is a start bit index and its low nibble is the field length minus one. The block decodes the descriptor and flags whether the field stays inside a 16-bit word, so a controller can skip fields that do not fit. The test pattern output is either all ones or generator B's state, chosen by a mode input.

An iteration counter counts advances. Each time it wraps from all ones to zero, a pass counter increments. A done flag rises once the pass counter exceeds a maximum-pass input. Seeding happens on the synchronous active-high reset.

Top module: `dual_lcg_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, the state is as follows. The descriptor is 8'h00 (generator A seed 16'h0053). The pattern in random mode is 16'h012E (generator B seed). The iteration and pass counters are zero and done is 0.
- R2: Generator A steps on an advance as `a_next = (2053*a + 16'h3619) mod 2^16`.
- R3: Generator B steps on an advance as `b_next = (2053*b + 16'h361D) mod 2^16`.
- R4: With advance low, neither generator state changes.
- R5: The descriptor equals bits 15:8 of generator A's state. field_start equals descriptor bits 7:4. field_len equals descriptor bits 3:0 plus one, as a 5-bit value from 1 to 16.
- R6: desc_valid is 1 exactly when field_start + field_len - 1 is below 16. Otherwise it is 0.
- R7: When rand_mode is 0, the pattern is 16'hFFFF. When rand_mode is 1, the pattern is generator B's current state.
- R8: The iteration counter increments by one, modulo 2^16, on each advance.
- R9: The pass counter increments exactly when an advance moves the iteration counter from 16'hFFFF to 0. At all other times it holds.
- R10: done is 1 exactly when the pass counter is greater than max_pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the seeds and clears the counters |
| advance | input | 1 | Steps both generators and the iteration counter |
| rand_mode | input | 1 | 0: pattern is all ones; 1: pattern is generator B state |
| max_pass | input | 16 | Pass limit for the done flag |
| descriptor | output | 8 | Upper byte of generator A state |
| field_start | output | 4 | Decoded start bit index |
| field_len | output | 5 | Decoded field length (1 to 16) |
| desc_valid | output | 1 | Field ends inside the word |
| pattern | output | 16 | Test pattern |
| iter_count | output | 16 | Advance counter |
| pass_count | output | 16 | Completed pass counter |
| done | output | 1 | Pass counter exceeds max_pass |

## Verification
The generators are checked against a reference that uses true multiplication. A single step would hide a wrong shift amount or a wrong increment on some states, so the bench runs a run of consecutive advances. It does this with random mode both on and off, which separates a stuck mode select from a faulty generator B. Idle stretches between strobes show whether state creeps without an advance. Descriptors that fit and descriptors that overrun are both seen during the run. A full 65536-step pass then exercises the wrap into the pass counter and both sides of the done comparison.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
    localparam int W       = 16;
    localparam int DESC_W  = 8;
    localparam int NIB_W   = 4;
    localparam int LEN_W   = NIB_W + 1;
    localparam int SH_LO   = 2;
    localparam int SH_HI   = 11;

    localparam logic [W-1:0] SEED_A = 16'o123;
    localparam logic [W-1:0] INCR_A = 16'o33031;
    localparam logic [W-1:0] SEED_B = 16'o456;
    localparam logic [W-1:0] INCR_B = 16'o33035;

    typedef struct packed {
        logic [NIB_W-1:0] start;
        logic [LEN_W-1:0] len;
        logic             fits;
    } field_t;

    // multiply by 1 + 4 + 2048 = 2053 using adds, then add increment
    function automatic logic [W-1:0] lcg_step(input logic [W-1:0] x,
                                              input logic [W-1:0] c);
        logic [W-1:0] t;
        t = x + (x << SH_LO);
        t = t + (x << SH_HI);
        return t + c;
    endfunction
endpackage

// File: rtl/lcg_core.sv
module lcg_core
    import lcg_pkg::*;
#(
    parameter logic [W-1:0] SEED = 16'h0001,
    parameter logic [W-1:0] INCR = 16'h0001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst)          state <= SEED;
        else if (advance) state <= lcg_step(state, INCR);
    end

    // R4: no strobe, no movement
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(state));
endmodule

// File: rtl/desc_check.sv
module desc_check
    import lcg_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output field_t            fld
);
    localparam int SUM_W = LEN_W + 1;
    logic [SUM_W-1:0] end_idx;

    always_comb begin
        fld.start = desc[DESC_W-1:NIB_W];
        fld.len   = {1'b0, desc[NIB_W-1:0]} + LEN_W'(1);
        end_idx   = SUM_W'(fld.start) + SUM_W'(fld.len) - SUM_W'(1);
        fld.fits  = (end_idx < SUM_W'(W));
    end
endmodule

// File: rtl/pass_tracker.sv
module pass_tracker
    import lcg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [W-1:0] max_pass,
    output logic [W-1:0] iter,
    output logic [W-1:0] pass,
    output logic         done
);
    logic wrap;
    assign wrap = advance && (iter == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            iter <= '0;
            pass <= '0;
        end else begin
            if (advance) iter <= iter + W'(1);
            if (wrap)    pass <= pass + W'(1);
        end
    end

    assign done = (pass > max_pass);

    p_iter_step_r8: assert property (@(posedge clk) disable iff (rst)
        advance |=> iter == $past(iter) + W'(1));
    p_pass_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (advance && iter == '1) |=> pass == $past(pass) + W'(1));
    p_pass_still_r9: assert property (@(posedge clk) disable iff (rst)
        !(advance && iter == '1) |=> $stable(pass));
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (done && pass != '1) ##1 $stable(max_pass) |-> done);
endmodule

// File: rtl/dual_lcg_gen.sv
module dual_lcg_gen
    import lcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              rand_mode,
    input  logic [W-1:0]      max_pass,
    output logic [DESC_W-1:0] descriptor,
    output logic [NIB_W-1:0]  field_start,
    output logic [LEN_W-1:0]  field_len,
    output logic              desc_valid,
    output logic [W-1:0]      pattern,
    output logic [W-1:0]      iter_count,
    output logic [W-1:0]      pass_count,
    output logic              done
);
    logic [W-1:0] st_a, st_b;
    field_t       fld;

    lcg_core #(.SEED(SEED_A), .INCR(INCR_A)) u_gen_a (
        .clk(clk), .rst(rst), .advance(advance), .state(st_a));
    lcg_core #(.SEED(SEED_B), .INCR(INCR_B)) u_gen_b (
        .clk(clk), .rst(rst), .advance(advance), .state(st_b));

    assign descriptor = st_a[W-1:W-DESC_W];

    desc_check u_desc (.desc(descriptor), .fld(fld));

    assign field_start = fld.start;
    assign field_len   = fld.len;
    assign desc_valid  = fld.fits;
    assign pattern     = rand_mode ? st_b : '1;

    pass_tracker u_pass (
        .clk(clk), .rst(rst), .advance(advance), .max_pass(max_pass),
        .iter(iter_count), .pass(pass_count), .done(done));

    // R6: a valid field never needs a length beyond the bits left above start
    p_valid_room_r6: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (5'(field_len) <= 5'(16) - 5'(field_start)));
    // R5: descriptor only moves with a strobe
    p_desc_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(descriptor));
endmodule

// File: tb/dual_lcg_gen_tb.sv
module dual_lcg_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, advance = 0, rand_mode = 0;
    logic [15:0] max_pass = 0;
    logic [7:0]  descriptor;
    logic [3:0]  field_start;
    logic [4:0]  field_len;
    logic        desc_valid, done;
    logic [15:0] pattern, iter_count, pass_count;

    int checks = 0, errors = 0;
    int ma, mb, miter, mpass;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_lcg_gen dut_i (.*);

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_model();
        ma = (ma * 2053 + 32'h3619) & 32'hFFFF;
        mb = (mb * 2053 + 32'h361D) & 32'hFFFF;
        miter = (miter + 1) & 32'hFFFF;
        if (miter == 0) mpass++;
    endtask

    task automatic check_fields();
        int s, l;
        s = (ma >> 12) & 15;
        l = ((ma >> 8) & 15) + 1;
        chk("R5 desc", descriptor, (ma >> 8) & 255);
        chk("R5 start", field_start, s);
        chk("R5 len", field_len, l);
        chk("R6 valid", desc_valid, (s + l - 1) < 16);
    endtask

    task automatic test_reset();
        rst = 1; advance = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        ma = 16'h0053; mb = 16'h012E; miter = 0; mpass = 0;
        rand_mode = 1; #1;
        chk("R1 desc", descriptor, 8'h00);
        chk("R1 pattern", pattern, 16'h012E);
        chk("R1 iter", iter_count, 0);
        chk("R1 pass", pass_count, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic test_steps(int n, logic mode);
        rand_mode = mode;
        for (int i = 0; i < n; i++) begin
            advance = 1;
            @(negedge clk);
            step_model();
            advance = 0;
            #1;
            check_fields();
            chk("R2 genA byte", descriptor, (ma >> 8) & 255);
            if (mode) chk("R3 genB", pattern, mb);
            else      chk("R7 ones", pattern, 16'hFFFF);
            chk("R8 iter", iter_count, miter);
        end
    endtask

    task automatic test_hold();
        advance = 0;
        repeat (5) @(negedge clk);
        rand_mode = 1; #1;
        chk("R4 hold A", descriptor, (ma >> 8) & 255);
        chk("R4 hold B", pattern, mb);
        chk("R8 hold iter", iter_count, miter);
        rand_mode = 0; #1;
        chk("R7 mode0", pattern, 16'hFFFF);
        rand_mode = 1; #1;
        chk("R7 mode1", pattern, mb);
    endtask

    task automatic test_pass();
        max_pass = 0;
        advance = 1;
        while (miter != 16'hFFFF) begin
            @(negedge clk);
            step_model();
        end
        advance = 0; #1;
        chk("R9 pre pass", pass_count, 0);
        chk("R10 not done", done, 0);
        chk("R8 at top", iter_count, 16'hFFFF);
        advance = 1;
        @(negedge clk);
        step_model();
        advance = 0; #1;
        chk("R8 wrap", iter_count, 0);
        chk("R9 pass", pass_count, 1);
        chk("R10 done", done, 1);
        chk("R3 long run", pattern, mb);
        check_fields();
        max_pass = 1; #1;
        chk("R10 limit eq", done, 0);
        repeat (2) @(negedge clk);
        chk("R9 stays", pass_count, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_steps(40, 1);
        test_hold();
        test_steps(40, 0);
        test_steps(20, 1);
        test_pass();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule